// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Pointer Logic

This block sits between a byte-wide host port and the two channels of a serial controller. Each channel has a small bank of write registers and a few readable registers. The host does not address these registers directly. Each channel keeps a pointer, and the host reaches a register through that channel's control offset. When the pointer is zero, a control write is taken as a command byte. That byte can load a new pointer value and can fire one-cycle command strobes. The next control access then goes to the register the pointer selects, and the pointer drops back to zero afterwards.

Two of the registers are asymmetric. The interrupt vector lives only on channel B, and the return-from-interrupt command is honoured only on channel A. A channel-reset command clears that channel's bank and pointer in a single write. Shifting, CRC logic and the status sources are outside this block. Status bytes arrive on input ports, and the stored register contents leave as parallel outputs.

Top module: `sio_regptr_top`

## Requirements
- R1: Port offsets: 0 is channel A data, 2 is channel A control, 4 is channel B data, 6 is channel B control. Accesses to data offsets or odd offsets change no register and no pointer. A read at any offset that is not a control offset returns 0x00.
- R2: After reset, every pointer is 0, every write register output is 0x00, and all command and CRC strobes are low.
- R3: A control write while the pointer is 0 loads the pointer from bits 2..0. The following control write stores its whole byte into the selected write register, which appears on `wregs[ch][n]` one cycle after the write.
- R4: Any control access, read or write, made while the pointer is non-zero returns the pointer to 0. The next control access then targets register 0.
- R5: A control read returns the value selected by the pointer:
  - pointer 0 returns `stat_rr0[ch]`;
  - pointer 1 returns `stat_rr1[ch]`;
  - pointer 2 returns channel B's stored vector on channel B and 0x00 on channel A;
  - pointers 3..7 return 0x00.
- R6: A command byte with bits 5..3 equal to k (1..7) raises `cmd_pulse[ch][k]` for exactly one cycle, in the cycle after the write. The codes are:
  - 1: abort;
  - 2: reset external/status interrupts;
  - 3: channel reset;
  - 4: enable interrupt on next received character;
  - 5: reset transmit-interrupt pending;
  - 6: error reset;
  - 7: return from interrupt.

  Code 0 raises nothing, and bit 0 of `cmd_pulse` never rises.
- R7: Code 7 raises `cmd_pulse[0][7]` on channel A. On channel B it raises no strobe.
- R8: A command byte with bits 7..6 equal to j (1..3) raises `crc_pulse[ch][j]` for one cycle, in the cycle after the write. The codes are: 1 resets the receive checker, 2 resets the transmit generator, and 3 resets the underrun/end-of-message latch. Code 0 raises nothing.
- R9: Command code 3 clears all write registers of that channel and forces its pointer to 0, even when bits 2..0 are non-zero. The other channel is unaffected.
- R10: Channel A has no register 2. A data write to it is discarded, `wregs[0][2]` stays 0x00, and the pointer still returns to 0.
- R11: The two channels keep independent pointers. A pointer loaded on one channel survives accesses to the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Host access strobe |
| wr_en | input | 1 | Write qualifier (wins over rd_en) |
| rd_en | input | 1 | Read qualifier |
| addr | input | 3 | Port offset |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte (combinational) |
| stat_rr0 | input | 2x8 | Per-channel status byte returned at pointer 0 |
| stat_rr1 | input | 2x8 | Per-channel status byte returned at pointer 1 |
| wregs | output | 2x7x8 | Stored write registers 1..7 per channel |
| cmd_pulse | output | 2x8 | One-hot command strobes, index = command code |
| crc_pulse | output | 2x4 | One-hot CRC-reset strobes, index = code |

## Verification
A pointer stuck at a wrong value shows on the very next control access. Either the read returns the wrong status byte, or a data byte lands in the wrong `wregs` slot one cycle later. Cross-channel leakage shows the same way: a loaded pointer is followed by traffic on the other channel before the data byte. A wrong command decode shows in the cycle right after the command write, as a missing, misplaced or doubled strobe. Clear and discard faults stay visible on the `wregs` outputs until the next write to that slot.

// File: rtl/sio_regptr_pkg.sv
package sio_regptr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      CMD_NULL       = 3'd0,
      CMD_ABORT      = 3'd1,
      CMD_RST_EXT    = 3'd2,
      CMD_CHAN_RST   = 3'd3,
      CMD_EN_RX_NEXT = 3'd4,
      CMD_RST_TXPEND = 3'd5,
      CMD_ERR_RST    = 3'd6,
      CMD_RET_INT    = 3'd7
   } cmd_code_e;

   typedef enum logic [1:0] {
      CRC_NULL   = 2'd0,
      CRC_RST_RX = 2'd1,
      CRC_RST_TX = 2'd2,
      CRC_RST_EOM = 2'd3
   } crc_code_e;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 3
) (
   input  logic              cs,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] ctl_wr,
   output logic [NUM_CH-1:0] ctl_rd
);
   localparam int CH_BIT = ADDR_W - 1;

   logic ctl_hit;
   assign ctl_hit = cs && !addr[0] && addr[1];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic ch_match;
      assign ch_match  = (addr[CH_BIT] == g[0]);
      assign ctl_wr[g] = ctl_hit && ch_match && wr_en;
      assign ctl_rd[g] = ctl_hit && ch_match && rd_en && !wr_en;
   end
endmodule

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_regptr_pkg::*;
#(
   parameter bit ALLOW_RETI = 1'b1
) (
   input  logic [BYTE_W-1:0] cmd_byte,
   output logic [7:0]        cmd_hot,
   output logic [3:0]        crc_hot,
   output logic              chan_rst
);
   cmd_code_e cmd;
   crc_code_e crc;

   assign cmd = cmd_code_e'(cmd_byte[5:3]);
   assign crc = crc_code_e'(cmd_byte[7:6]);
   assign chan_rst = (cmd == CMD_CHAN_RST);

   always_comb begin
      cmd_hot = '0;
      if (cmd != CMD_NULL && (cmd != CMD_RET_INT || ALLOW_RETI))
         cmd_hot[cmd] = 1'b1;
      crc_hot = '0;
      if (crc != CRC_NULL)
         crc_hot[crc] = 1'b1;
   end
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
   import sio_regptr_pkg::*;
#(
   parameter int NUM_WREG   = 8,
   parameter bit HAS_VEC    = 1'b0,
   parameter bit ALLOW_RETI = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ctl_wr,
   input  logic                           ctl_rd,
   input  logic [BYTE_W-1:0]              wdata,
   input  logic [BYTE_W-1:0]              stat0,
   input  logic [BYTE_W-1:0]              stat1,
   output logic [NUM_WREG-1:1][BYTE_W-1:0] wregs,
   output logic [7:0]                     cmd_pulse,
   output logic [3:0]                     crc_pulse,
   output logic [BYTE_W-1:0]              rd_val
);
   localparam int PTR_W = $clog2(NUM_WREG);
   localparam logic [PTR_W-1:0] VEC_PTR = PTR_W'(2);

   logic [PTR_W-1:0]               ptr_q;
   logic [NUM_WREG-1:1][BYTE_W-1:0] wreg_q;
   logic [7:0]                     cmd_q;
   logic [3:0]                     crc_q;
   logic [7:0]                     dec_cmd;
   logic [3:0]                     dec_crc;
   logic                           dec_rst;
   logic                           keep_wr;
   logic [BYTE_W-1:0]              vec_val;

   sio_cmd_decode #(.ALLOW_RETI(ALLOW_RETI)) u_dec (
      .cmd_byte (wdata),
      .cmd_hot  (dec_cmd),
      .crc_hot  (dec_crc),
      .chan_rst (dec_rst)
   );

   if (HAS_VEC) begin : g_vec
      assign keep_wr = 1'b1;
      assign vec_val = wreg_q[VEC_PTR];
   end else begin : g_novec
      assign keep_wr = (ptr_q != VEC_PTR);
      assign vec_val = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         wreg_q <= '0;
         cmd_q  <= '0;
         crc_q  <= '0;
      end else begin
         cmd_q <= '0;
         crc_q <= '0;
         if (ctl_wr) begin
            if (ptr_q == '0) begin
               cmd_q <= dec_cmd;
               crc_q <= dec_crc;
               if (dec_rst) begin
                  ptr_q  <= '0;
                  wreg_q <= '0;
               end else begin
                  ptr_q <= wdata[PTR_W-1:0];
               end
            end else begin
               if (keep_wr) wreg_q[ptr_q] <= wdata;
               ptr_q <= '0;
            end
         end else if (ctl_rd && ptr_q != '0) begin
            ptr_q <= '0;
         end
      end
   end

   always_comb begin
      case (ptr_q)
         PTR_W'(0): rd_val = stat0;
         PTR_W'(1): rd_val = stat1;
         VEC_PTR:   rd_val = vec_val;
         default:   rd_val = '0;
      endcase
   end

   assign wregs     = wreg_q;
   assign cmd_pulse = cmd_q;
   assign crc_pulse = crc_q;

   // R4
   ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_wr || ctl_rd) && ptr_q != '0) |=> (ptr_q == '0));
   // R6
   cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot0(cmd_pulse) && !cmd_pulse[0]));
   // R6
   cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pulse != '0 || crc_pulse != '0) |-> $past(ctl_wr));
   // R9
   chan_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ptr_q == '0 && wdata[5:3] == 3'd3) |=> (ptr_q == '0 && wregs == '0));
   // R3
   wreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(wregs));

   if (!HAS_VEC) begin : g_novec_chk
      // R10
      no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wregs[VEC_PTR] == '0);
   end
endmodule

// File: rtl/sio_regptr_top.sv
module sio_regptr_top
   import sio_regptr_pkg::*;
#(
   parameter int NUM_WREG = 8,
   parameter int VEC_CH   = 1,
   parameter int RETI_CH  = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cs,
   input  logic                                 wr_en,
   input  logic                                 rd_en,
   input  logic [2:0]                           addr,
   input  logic [BYTE_W-1:0]                    wdata,
   output logic [BYTE_W-1:0]                    rdata,
   input  logic [1:0][BYTE_W-1:0]               stat_rr0,
   input  logic [1:0][BYTE_W-1:0]               stat_rr1,
   output logic [1:0][NUM_WREG-1:1][BYTE_W-1:0] wregs,
   output logic [1:0][7:0]                      cmd_pulse,
   output logic [1:0][3:0]                      crc_pulse
);
   localparam int NUM_CH = 2;
   localparam int PTR_W  = $clog2(NUM_WREG);

   if (NUM_WREG < 4 || NUM_WREG > 8 || (1 << PTR_W) != NUM_WREG) begin : g_bad_wreg
      $error("NUM_WREG must be 4 or 8");
   end
   if (VEC_CH < 0 || VEC_CH >= NUM_CH || RETI_CH < 0 || RETI_CH >= NUM_CH) begin : g_bad_ch
      $error("VEC_CH and RETI_CH must name an existing channel");
   end

   logic [NUM_CH-1:0]             ctl_wr;
   logic [NUM_CH-1:0]             ctl_rd;
   logic [NUM_CH-1:0][BYTE_W-1:0] rd_val;

   sio_port_decode #(.NUM_CH(NUM_CH), .ADDR_W(3)) u_decode (
      .cs     (cs),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .ctl_wr (ctl_wr),
      .ctl_rd (ctl_rd)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      sio_chan_regs #(
         .NUM_WREG   (NUM_WREG),
         .HAS_VEC    (g == VEC_CH),
         .ALLOW_RETI (g == RETI_CH)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_wr    (ctl_wr[g]),
         .ctl_rd    (ctl_rd[g]),
         .wdata     (wdata),
         .stat0     (stat_rr0[g]),
         .stat1     (stat_rr1[g]),
         .wregs     (wregs[g]),
         .cmd_pulse (cmd_pulse[g]),
         .crc_pulse (crc_pulse[g]),
         .rd_val    (rd_val[g])
      );
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (ctl_rd[c]) rdata = rd_val[c];
   end

   // R1
   one_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_wr, ctl_rd}));
   // R7
   b_no_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_pulse[VEC_CH == RETI_CH ? 0 : 1 - RETI_CH][7]);
endmodule

// File: tb/sio_regptr_top_bench.sv
module sio_regptr_top_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0][7:0] stat_rr0 = {8'hB0, 8'hA0};
   logic [1:0][7:0] stat_rr1 = {8'hB1, 8'hA1};
   logic [1:0][7:1][7:0] wregs;
   logic [1:0][7:0] cmd_pulse;
   logic [1:0][3:0] crc_pulse;

   logic [1:0][7:0] cmd_s;
   logic [1:0][3:0] crc_s;
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   sio_regptr_top u_sio_regptr_top (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .stat_rr0(stat_rr0),
      .stat_rr1(stat_rr1), .wregs(wregs), .cmd_pulse(cmd_pulse),
      .crc_pulse(crc_pulse)
   );

   // entry: [11] channel, [10:8] register, [7:0] data
   localparam logic [11:0] TBL [8] = '{12'h111, 12'h333, 12'h777, 12'hA5A,
                                       12'hDC5, 12'h444, 12'hFE7, 12'h99E};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
      @(posedge clk); #1;
      cmd_s = cmd_pulse; crc_s = crc_pulse;
      cs = 1'b0; wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd_en = 1'b1; wr_en = 1'b0; addr = a;
      #1 d = rdata;
      @(posedge clk); #1;
      cs = 1'b0; rd_en = 1'b0;
   endtask

   function automatic logic [2:0] ctl(input logic ch);
      return ch ? 3'd6 : 3'd2;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(posedge clk);
      #1;
      // R2 reset state
      chk("R2 wregs", 32'(wregs == '0), 32'd1);
      chk("R2 strobes", {cmd_pulse, crc_pulse}, '0);
      chk("R2 rdata idle", rdata, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      bus_rd(3'd2, rv);
      chk("R5 ptr0 A status", rv, 8'hA0);

      // R3 table of pointer/data pairs
      for (int i = 0; i < 8; i++) begin
         logic ch; logic [2:0] r; logic [7:0] d;
         ch = TBL[i][11]; r = TBL[i][10:8]; d = TBL[i][7:0];
         bus_wr(ctl(ch), {5'b0, r});
         bus_wr(ctl(ch), d);
         chk("R3 table store", wregs[ch][r], d);
      end
      // R4 pointer back at 0 after data write
      bus_rd(3'd2, rv);
      chk("R4 ptr returned after write", rv, 8'hA0);

      // R5 read mux
      bus_wr(3'd2, 8'h01); bus_rd(3'd2, rv);
      chk("R5 ptr1 A", rv, 8'hA1);
      bus_rd(3'd2, rv);
      chk("R4 ptr returned after read", rv, 8'hA0);
      bus_wr(3'd6, 8'h02); bus_rd(3'd6, rv);
      chk("R5 ptr2 B vector", rv, 8'h5A);
      bus_wr(3'd2, 8'h02); bus_rd(3'd2, rv);
      chk("R5 ptr2 A zero", rv, 8'h00);
      bus_wr(3'd6, 8'h06); bus_rd(3'd6, rv);
      chk("R5 ptr6 B zero", rv, 8'h00);

      // R10 channel A register 2 absent
      bus_wr(3'd2, 8'h02); bus_wr(3'd2, 8'hFF);
      chk("R10 A reg2 stays 0", wregs[0][2], 8'h00);
      bus_rd(3'd2, rv);
      chk("R10 ptr returned", rv, 8'hA0);

      // R6 command strobes
      bus_wr(3'd2, 8'h08);
      chk("R6 A abort", cmd_s[0], 8'h02);
      chk("R8 no crc with cmd only", crc_s[0], 4'h0);
      @(posedge clk); #1;
      chk("R6 one cycle", cmd_pulse, '0);
      bus_wr(3'd6, 8'h30);
      chk("R6 B error reset", cmd_s[1], 8'h40);
      bus_wr(3'd2, 8'h20);
      chk("R6 A rx next", cmd_s[0], 8'h10);

      // R7 return from interrupt only on A
      bus_wr(3'd6, 8'h38);
      chk("R7 B no reti", cmd_s[1], 8'h00);
      bus_wr(3'd2, 8'h38);
      chk("R7 A reti", cmd_s[0], 8'h80);

      // R8 crc strobes
      bus_wr(3'd2, 8'h40);
      chk("R8 A rx crc", crc_s[0], 4'b0010);
      bus_wr(3'd6, 8'hC0);
      chk("R8 B eom", crc_s[1], 4'b1000);
      bus_wr(3'd2, 8'h80);
      chk("R8 A tx crc", crc_s[0], 4'b0100);

      // R9 channel reset with non-zero pointer bits
      bus_wr(3'd6, 8'h1D);
      chk("R9 strobe", cmd_s[1], 8'h08);
      chk("R9 B cleared", 32'(wregs[1] == '0), 32'd1);
      chk("R9 A intact", wregs[0][1], 8'h11);
      bus_rd(3'd6, rv);
      chk("R9 ptr zero", rv, 8'hB0);

      // R11 independent pointers
      bus_wr(3'd2, 8'h01);
      bus_wr(3'd6, 8'h03);
      bus_wr(3'd6, 8'h3C);
      chk("R11 B store", wregs[1][3], 8'h3C);
      bus_wr(3'd2, 8'h1F);
      chk("R11 A pointer kept", wregs[0][1], 8'h1F);

      // R1 data and odd offsets leave pointer and registers alone
      bus_wr(3'd2, 8'h04);
      bus_wr(3'd0, 8'h99);
      bus_wr(3'd3, 8'h99);
      bus_wr(3'd4, 8'h99);
      bus_rd(3'd0, rv);
      chk("R1 data read zero", rv, 8'h00);
      bus_rd(3'd7, rv);
      chk("R1 odd read zero", rv, 8'h00);
      chk("R1 reg4 untouched", wregs[0][4], 8'h44);
      bus_wr(3'd2, 8'h66);
      chk("R1 pointer survived", wregs[0][4], 8'h66);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule